// File: doc/BRIEF.md
# Key-Gated Warm Reset Pulse Generator

This block lets software ask for a warm reset of a processor by writing a control register. The request is honoured only while an unlock value sits in a separate 8-bit key register. Once accepted, the block drives an active-low reset output and releases it by itself after a fixed time of one microsecond. The length of that time is counted in clock cycles from the clock frequency parameter.

A bus front end supplies a one-cycle write strobe with address and data, and a read address. Read data is combinational from the read address. Software is expected to overwrite the key with another value after a successful reset request. The key is not cleared by hardware. Register map with the default parameters: control at address 0, key at address 1, other addresses unmapped.

Top module: `warm_reset_pulse`

## Requirements
- R1: After power-on reset the key reads 0x00, the control register reads 0x20 and `warm_rst_n` is 1.
- R2: A write to the key address stores all 8 data bits, which read back unchanged until the next key write.
- R3: A control read returns the current reset level in bit 5 (1 idle, 0 during a pulse), with bits 7:6 and 4:0 always 0.
- R4: A control write with data bit 5 = 0 while the key holds 0xA8 and no pulse is running drives `warm_rst_n` to 0 from the clock edge that takes the write.
- R5: A control write with data bit 5 = 0 while the key is not 0xA8 is ignored, and `warm_rst_n` stays 1.
- R6: A pulse keeps `warm_rst_n` low for exactly CLK_HZ/1,000,000 × PULSE_US clock cycles (250 cycles with the defaults) and then returns it to 1 without any write.
- R7: Control writes of any value during a running pulse neither extend nor shorten it.
- R8: A control write with data bit 5 = 1 while idle leaves `warm_rst_n` at 1, and the other data bits of a control write have no effect.
- R9: The key keeps its value after a pulse ends, and once software writes a different key a further reset write is ignored.
- R10: Writes to unmapped addresses change neither register, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| warm_rst_n | output | 1 | Active-low warm reset pulse to the processor |

## Verification
A write that starts a pulse changes `warm_rst_n` and the control readback right after the clock edge that takes the strobe, so the bench drives on the falling edge and samples on the next falling edge. Key writes are visible on the read port at the same point. The pulse width is counted by the bench on every rising edge where the old output is low, and the count is compared with 250 when the output rises again. In the random phase a bench reference model steps on each rising edge, and the design is compared with it one nanosecond after each falling edge.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

  localparam logic [7:0] UNLOCK_KEY = 8'hA8;
  localparam int         RST_BIT    = 5;

  // Pulse length in clock cycles for a frequency and a duration in us.
  function automatic int pulse_cycles(input int clk_hz, input int dur_us);
    return (clk_hz / 1_000_000) * dur_us;
  endfunction

  // Control register image: only the reset level bit is live.
  function automatic logic [7:0] ctrl_view(input logic level_n);
    logic [7:0] v;
    v          = 8'h00;
    v[RST_BIT] = level_n;
    return v;
  endfunction

  function automatic logic key_ok(input logic [7:0] k);
    return k == UNLOCK_KEY;
  endfunction

endpackage

// File: rtl/wrp_key_reg.sv
module wrp_key_reg
  import wrp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic [7:0] key_q,
  output logic       unlocked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= 8'h00;
    else if (wr_stb) key_q <= wr_data;
  end

  assign unlocked = key_ok(key_q);

  assert_key_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> key_q == $past(wr_data));

  assert_key_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(key_q));

endmodule

// File: rtl/wrp_pulse_timer.sv
module wrp_pulse_timer #(
  parameter int PULSE_CYC = 250,
  localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic             level_n,
  output logic             active,
  output logic             start,
  output logic             done,
  output logic [CNT_W-1:0] remain
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  assign active = !level_n;
  assign start  = fire && !active;
  assign done   = active && (remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_n <= 1'b1;
      remain  <= '0;
    end else if (start) begin
      level_n <= 1'b0;
      remain  <= LOAD;
    end else if (done) begin
      level_n <= 1'b1;
      remain  <= '0;
    end else if (active) begin
      remain  <= remain - ONE;
    end
  end

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !level_n);

  assert_self_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> level_n);

  assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> (remain == $past(remain) - ONE) && !level_n);

endmodule

// File: rtl/wrp_read_mux.sv
module wrp_read_mux
  import wrp_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 1
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        key_q,
  input  logic              level_n,
  output logic [7:0]        rd_data
);

  always_comb begin
    if (rd_addr == KEY_ADDR)       rd_data = key_q;
    else if (rd_addr == CTRL_ADDR) rd_data = ctrl_view(level_n);
    else                           rd_data = 8'h00;
  end

endmodule

// File: rtl/warm_reset_pulse.sv
module warm_reset_pulse
  import wrp_pkg::*;
#(
  parameter int                CLK_HZ    = 250_000_000,
  parameter int                PULSE_US  = 1,
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              warm_rst_n
);

  localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_US);
  localparam int CNT_W     = $clog2(PULSE_CYC + 1);
  localparam int RUN_W     = CNT_W + 1;

  logic [7:0]       key_q;
  logic             unlocked;
  logic             key_wr, ctrl_wr, fire;
  logic             active, start, done;
  logic [CNT_W-1:0] remain;

  assign key_wr  = wr_en && (wr_addr == KEY_ADDR);
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign fire    = ctrl_wr && !wr_data[RST_BIT] && unlocked;

  wrp_key_reg u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (key_wr),
    .wr_data  (wr_data),
    .key_q    (key_q),
    .unlocked (unlocked)
  );

  wrp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .level_n (warm_rst_n),
    .active  (active),
    .start   (start),
    .done    (done),
    .remain  (remain)
  );

  wrp_read_mux #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .KEY_ADDR  (KEY_ADDR)
  ) u_rd (
    .rd_addr (rd_addr),
    .key_q   (key_q),
    .level_n (warm_rst_n),
    .rd_data (rd_data)
  );

  // Independent low-time counter used only by the width checks.
  logic [RUN_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (warm_rst_n) low_run <= '0;
    else                 low_run <= low_run + RUN_W'(1);
  end

  assert_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[RST_BIT] && !unlocked && warm_rst_n) |=> warm_rst_n);

  assert_bit_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[RST_BIT] && warm_rst_n) |=> warm_rst_n);

  assert_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_rst_n) |-> low_run == RUN_W'(PULSE_CYC));

  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RUN_W'(PULSE_CYC));

  assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == CTRL_ADDR) |-> (rd_data & 8'hDF) == 8'h00);

endmodule

// File: tb/warm_reset_pulse_test.sv
module warm_reset_pulse_test;

  localparam int         CLK_HZ = 250_000_000;
  localparam int         DUR_US = 1;
  localparam int         AW     = 2;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_KEY  = 2'd1;
  localparam int         WIDTH  = (CLK_HZ / 1_000_000) * DUR_US;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic          warm_rst_n;

  always #2 clk = ~clk;

  warm_reset_pulse uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .warm_rst_n (warm_rst_n)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  function automatic logic [7:0] exp_read(logic [1:0] a, logic [7:0] k, int left);
    if (a == A_KEY)  return k;
    if (a == A_CTRL) return (left == 0) ? 8'b0010_0000 : 8'b0000_0000;
    return 8'h00;
  endfunction

  // Reference model, stepped on rising edges.
  logic [7:0] m_key;
  int         m_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_key  <= 8'h00;
      m_left <= 0;
    end else begin
      if (m_left > 0) m_left <= m_left - 1;
      else if (wr_en && wr_addr == A_CTRL && wr_data[5] == 1'b0 && m_key == 8'hA8)
        m_left <= WIDTH;
      if (wr_en && wr_addr == A_KEY) m_key <= wr_data;
    end
  end

  // Bench-side pulse width measurement.
  int low_cnt = 0, last_width = -1, n_pulses = 0;
  always @(posedge clk) begin
    if (rst_n && !warm_rst_n) low_cnt <= low_cnt + 1;
    else if (rst_n && low_cnt != 0) begin
      last_width <= low_cnt;
      n_pulses   <= n_pulses + 1;
      low_cnt    <= 0;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic readv(logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150_000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int pulses0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 level", {7'd0, warm_rst_n}, 8'h01);
    readv(A_CTRL, v); check("R1 ctrl", v, 8'h20);
    readv(A_KEY, v);  check("R1 key", v, 8'h00);
    readv(2'd2, v);   check("R10 unmapped read", v, 8'h00);

    // R5 locked write
    write(A_CTRL, 8'h00);
    check("R5 level", {7'd0, warm_rst_n}, 8'h01);
    idle(3);
    readv(A_CTRL, v); check("R5 ctrl", v, 8'h20);

    // R2 key storage
    write(A_KEY, 8'h5C);
    readv(A_KEY, v); check("R2 key 5C", v, 8'h5C);
    write(A_CTRL, 8'h00);
    check("R5 wrong key", {7'd0, warm_rst_n}, 8'h01);
    write(A_KEY, 8'hA8);
    readv(A_KEY, v); check("R2 key A8", v, 8'hA8);

    // R10 unmapped writes
    write(2'd3, 8'h00);
    write(2'd2, 8'h13);
    readv(A_KEY, v);  check("R10 key kept", v, 8'hA8);
    readv(A_CTRL, v); check("R10 ctrl kept", v, 8'h20);
    check("R10 level", {7'd0, warm_rst_n}, 8'h01);

    // R8 bit 5 high, other bits set
    write(A_CTRL, 8'hFF);
    check("R8 level", {7'd0, warm_rst_n}, 8'h01);
    readv(A_CTRL, v); check("R8 ctrl", v, 8'h20);

    // R4 accepted write, other bits ignored
    pulses0 = n_pulses;
    write(A_CTRL, 8'hDF);
    check("R4 level low", {7'd0, warm_rst_n}, 8'h00);
    readv(A_CTRL, v); check("R3 ctrl during pulse", v, 8'h00);

    // R7 writes mid-pulse
    idle(100);
    write(A_CTRL, 8'h00);
    write(A_CTRL, 8'h20);
    check("R7 still low", {7'd0, warm_rst_n}, 8'h00);
    idle(WIDTH);
    check("R6 released", {7'd0, warm_rst_n}, 8'h01);
    check("R6 one pulse", 8'(n_pulses - pulses0), 8'h01);
    check("R6 width", 8'(last_width), 8'(WIDTH));
    readv(A_CTRL, v); check("R3 ctrl after", v, 8'h20);

    // R9 key persists; changed key locks
    readv(A_KEY, v); check("R9 key kept", v, 8'hA8);
    write(A_KEY, 8'h00);
    write(A_CTRL, 8'h00);
    check("R9 relocked", {7'd0, warm_rst_n}, 8'h01);
    idle(2);

    // Random phase against the reference model
    for (int it = 0; it < 3000; it++) begin
      int op;
      @(negedge clk);
      #1;
      n_run++;
      if (rd_data !== exp_read(rd_addr, m_key, m_left) ||
          warm_rst_n !== (m_left == 0)) begin
        n_fail++;
        $display("FAIL R4/R5/R6/R7 random: actual rd=0x%02h lvl=%0b expected rd=0x%02h lvl=%0b",
                 rd_data, warm_rst_n, exp_read(rd_addr, m_key, m_left), (m_left == 0));
      end
      op      = int'($urandom_range(0, 9));
      rd_addr = AW'($urandom_range(0, 3));
      wr_en   = 1'b0;
      if (op < 2) begin
        wr_en = 1'b1; wr_addr = A_KEY;
        wr_data = ($urandom_range(0, 1) == 0) ? 8'hA8 : 8'($urandom);
      end else if (op < 4) begin
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 8'($urandom);
      end else if (op == 4) begin
        wr_en = 1'b1; wr_addr = AW'($urandom_range(2, 3)); wr_data = 8'($urandom);
      end
    end
    wr_en = 1'b0;
    idle(2);
    finish_run();
  end

endmodule